// File: doc/BRIEF.md
# Chainable Presettable Binary Up-Counter

The block is a synchronous up-counter built from identical 4-bit slices. All state changes on the rising clock edge. A single active-low clear sets the count to zero. A single active-low load copies a parallel word into the count. Two active-high enables, a parallel enable and a carry enable, must both be high for the count to advance. A terminal-count flag rises when the carry enable is high and every count bit is one. The flag is combinational on the carry enable, so it does not wait for a clock edge.

Inside the top module, the terminal-count flag of each slice drives the carry enable of the next slice. Clear, load and the parallel enable go to every slice. Every slice uses the one clock, with no ripple clocking. The result is a `SLICES`×4-bit counter that steps by exactly one on each enabled edge.

An elaboration-time option shortens the modulus. When the count equals `MODULUS-1` and the next edge would advance it, an internal clear is raised, so the count returns straight to zero. No stray state appears in between. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status line, sampled only at the clock edge.

Top module: `cnt_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, the whole count becomes zero on that edge. This holds whatever the levels of `ld_n`, `en_par` and `en_car`.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `q` takes the value of `din`. This holds whatever the levels of both enables.
- R3: When `clr_n`, `ld_n`, `en_par` and `en_car` are all high, the count increases by exactly one on the edge.
- R4: When `clr_n` and `ld_n` are high and either enable is low, the count keeps its value.
- R5: `tc` is high exactly when `en_car` is high and every bit of `q` is 1. A change on `en_car` reaches `tc` with no clock edge.
- R6: An enabled count from all-ones wraps to all-zeros.
- R7: Across slice boundaries the full-width count steps by one; for example 0x0F becomes 0x10, with no slice skipping or lagging.
- R8: The final `tc` never goes high unless every bit of the full-width count is 1.
- R9: With `MOD_ON` set, an enabled count edge with `ld_n` high at count `MODULUS-1` gives zero. From a clear, the sequence runs 0 to `MODULUS-1` and repeats.
- R10: Changes on `clr_n`, `ld_n`, `en_par`, `en_car` and `din` between edges leave `q` unchanged. Only the `tc` path from `en_car` responds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, active high, shared by all slices |
| en_car | input | 1 | Carry count enable, active high, also gates `tc` |
| din | input | 4*SLICES | Parallel load word |
| q | output | 4*SLICES | Current count |
| tc | output | 1 | Terminal count of the last slice |

## Verification
A reference model applies the order clear, then load, then count, then hold. Random stimulus covers all four control lines on every cycle, and each mode of the model is compared against the design.

Several directed cases target specific faults:
- A load to 0xFC followed by counting crosses both the nibble carry and the full wrap. This separates a correct carry chain from one that drops or repeats a step.
- Holding with only one enable low at a time shows that each enable acts on its own.
- Lowering `en_car` while the count is all ones shows that `tc` follows it with no clock edge.
- A second instance with the modulus option set runs a full 0 to 9 cycle.
- Controls toggled between edges must leave `q` untouched.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int SLICE_W = 4;
  typedef logic [SLICE_W-1:0] nib_t;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic ld_n,
  input  logic en_par,
  input  logic en_car,
  input  nib_t din,
  output nib_t q,
  output logic tc
);

  nib_t cnt_r;

  always_ff @(posedge clk) begin
    if (!clr_n)                cnt_r <= '0;
    else if (!ld_n)            cnt_r <= din;
    else if (en_par && en_car) cnt_r <= cnt_r + nib_t'(1);
  end

  assign q  = cnt_r;
  assign tc = en_car && (&cnt_r);

  AST_CLR_ZERO: assert property (@(posedge clk)
    !clr_n |=> (cnt_r == '0)); // R1
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && !ld_n) |=> (cnt_r == $past(din))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && ld_n && en_par && en_car) |=> (cnt_r == nib_t'($past(cnt_r) + nib_t'(1)))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && ld_n && !(en_par && en_car)) |=> $stable(cnt_r)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && ld_n && en_par && en_car && (&cnt_r)) |=> (cnt_r == '0)); // R6

endmodule

// File: rtl/cnt_wrap_det.sv
module cnt_wrap_det #(
  parameter int WIDTH   = 8,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] q,
  input  logic             ld_n,
  input  logic             en_par,
  input  logic             en_car,
  output logic             wrap
);

  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  assign wrap = (q == LAST) && ld_n && en_par && en_car;

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int SLICES  = 2,
  parameter bit MOD_ON  = 1'b0,
  parameter int MODULUS = 10
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        ld_n,
  input  logic                        en_par,
  input  logic                        en_car,
  input  logic [SLICES*SLICE_W-1:0]   din,
  output logic [SLICES*SLICE_W-1:0]   q,
  output logic                        tc
);

  localparam int WIDTH = SLICES * SLICE_W;
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [SLICES:0] carry;
  logic            slice_clr_n;

  generate
    if (MOD_ON) begin : g_mod
      logic wrap;
      cnt_wrap_det #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_det (
        .q(q), .ld_n(ld_n), .en_par(en_par), .en_car(en_car), .wrap(wrap)
      );
      assign slice_clr_n = clr_n && !wrap;

      AST_MOD_RETURN: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_par && en_car && (q == LAST)) |=> (q == '0)); // R9
    end else begin : g_full
      assign slice_clr_n = clr_n;
    end
  endgenerate

  assign carry[0] = en_car;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    cnt_slice u_slice (
      .clk   (clk),
      .clr_n (slice_clr_n),
      .ld_n  (ld_n),
      .en_par(en_par),
      .en_car(carry[i]),
      .din   (din[i*SLICE_W +: SLICE_W]),
      .q     (q[i*SLICE_W +: SLICE_W]),
      .tc    (carry[i+1])
    );
  end

  assign tc = carry[SLICES];

  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_par && en_car && !(MOD_ON && (q == LAST)))
      |=> (q == WIDTH'($past(q) + WIDTH'(1)))); // R7
  AST_TC_FULL: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> ((&q) && en_car)); // R8

endmodule

// File: tb/cnt_chain_test.sv
`timescale 1ns/1ps
module cnt_chain_test;
  localparam int SL  = 2;
  localparam int W   = SL * 4;
  localparam int MOD = 10;

  logic clk = 1'b0;
  logic clr_n = 1'b0, ld_n = 1'b1, en_par = 1'b0, en_car = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q, qm;
  logic tc, tcm;
  logic [W-1:0] m_q, m_qm;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cnt_chain #(.SLICES(SL), .MOD_ON(1'b0), .MODULUS(MOD)) uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_par(en_par), .en_car(en_car),
    .din(din), .q(q), .tc(tc));
  cnt_chain #(.SLICES(SL), .MOD_ON(1'b1), .MODULUS(MOD)) uut_mod (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_par(en_par), .en_car(en_car),
    .din(din), .q(qm), .tc(tcm));

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic c,
      input logic l, input logic ep, input logic ec, input logic [W-1:0] d, input bit modon);
    if (!c) return '0;
    if (!l) return d;
    if (ep && ec) begin
      if (modon && cur == W'(MOD - 1)) return '0;
      return cur + W'(1);
    end
    return cur;
  endfunction

  function automatic logic ref_tc(input logic [W-1:0] cur, input logic ec);
    return ec && (cur == '1);
  endfunction

  function automatic string tag_of(input logic [W-1:0] cur, input logic c, input logic l,
      input logic ep, input logic ec, input bit modon);
    if (!c) return "R1";
    if (!l) return "R2";
    if (!(ep && ec)) return "R4";
    if (modon && cur == W'(MOD - 1)) return "R9";
    if (cur == '1) return "R6";
    if (cur[3:0] == 4'hF) return "R7";
    return "R3";
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic ep, input logic ec,
      input logic [W-1:0] d, input bit glitch);
    logic [W-1:0] hold_q, hold_qm;
    string t0, t1;
    @(negedge clk);
    clr_n = c; ld_n = l; en_par = ep; en_car = ec; din = d;
    #0.5;
    chk("R5", W'(tc), W'(ref_tc(m_q, ec)));
    chk("R8", W'(tcm), W'(ref_tc(m_qm, ec)));
    if (glitch) begin
      hold_q = q; hold_qm = qm;
      clr_n = ~c; ld_n = ~l; en_par = ~ep; din = ~d;
      #0.5;
      chk("R10", q, hold_q);
      chk("R10", qm, hold_qm);
      clr_n = c; ld_n = l; en_par = ep; din = d;
    end
    t0 = tag_of(m_q, c, l, ep, ec, 1'b0);
    t1 = tag_of(m_qm, c, l, ep, ec, 1'b1);
    m_q  = ref_next(m_q, c, l, ep, ec, d, 1'b0);
    m_qm = ref_next(m_qm, c, l, ep, ec, d, 1'b1);
    @(posedge clk);
    #1;
    chk(t0, q, m_q);
    chk(t1, qm, m_qm);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_q = '0; m_qm = '0;
    // R1: reset state, clear with load low and enables high
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0);
    // R2: load ignores enables being low
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFC, 1'b0);
    // R3 R6 R7: count 0xFC..0xFF, wrap, continue
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
    // R7: nibble carry 0x0F -> 0x10
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
    // R4: each enable low alone
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    // R5 R8: all ones, tc follows en_car combinationally
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    // R9: full modulus cycle from clear
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
    // R10: glitches between edges
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 1'b1);
    // random mix against the reference model
    for (int i = 0; i < 4000; i++) begin
      logic c, l, ep, ec;
      c  = ($urandom % 16) != 0;
      l  = ($urandom % 8) != 0;
      ep = ($urandom % 4) != 0;
      ec = ($urandom % 4) != 0;
      step(c, l, ep, ec, W'($urandom), ($urandom % 4) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule